// File: doc/BRIEF.md
# Bridge Driver Operating-Mode and Fault Reporting Controller

This block decides the operating mode of a four-MOSFET bridge driver and reports its health on a single active-low error line. Its inputs are an enable line and fault flags that have already been filtered:

- supply undervoltage lockout
- short circuit
- open short-circuit-level pin
- regulator undervoltage
- overvoltage, overtemperature and overcurrent

It also takes an indication that the bootstrap capacitors are charged. From these it produces four outputs. The first is the error flag. The second is a command that forces every gate off. The third is a command that turns on both low sides to charge the bootstraps. The fourth is a sleep indication that switches off the regulator and charge pump.

Faults fall into three classes. Warnings leave the gates running. Self-clearing errors force the gates off while the fault is present. A short circuit latches the error until the enable line is reset. Timing is measured in microseconds, counted by a prescaler from the clock. A low pulse on enable counts only once it lasts a minimum time. A longer low period walks the controller through a timed go-to-sleep window into sleep.

Top module: `bdrv_mode_ctrl`

## Requirements
- R1: After reset the controller is asleep: err_n_o=0, gates_off_o=1, bs_charge_o=0, sleep_o=1.
- R2: Enable high while asleep starts wake-up: bs_charge_o=1, gates_off_o=1, err_n_o=0, sleep_o=0. Wake-up ends in normal run (err_n_o=1, gates_off_o=0, bs_charge_o=0) when bs_ready_i is high and no fault is present.
- R3: Enable held low for RST_US microseconds enters go-to-sleep: gates_off_o=1, err_n_o=0, sleep_o=0. Held low for SLEEP_US microseconds in total, it gives sleep_o=1. A rising enable before then goes straight back to wake-up.
- R4: Supply undervoltage from any awake mode gives gates_off_o=1, sleep_o=1, err_n_o=0. This persists after the fault clears, until enable has been low for RST_US microseconds and rises again.
- R5: Overvoltage, overtemperature or overcurrent in run gives err_n_o=0 with gates_off_o=0. Removing the condition returns err_n_o=1.
- R6: Regulator undervoltage or an open level pin gives err_n_o=0 and gates_off_o=1. Both clear by themselves when the condition is removed.
- R7: A short circuit gives err_n_o=0 and gates_off_o=1, and this state stays after the short circuit flag drops.
- R8: Priority: supply undervoltage above short circuit, short circuit above open pin, forcing errors above warnings.
- R9: An enable low pulse shorter than RST_US microseconds changes neither the mode nor the outputs. A longer one clears a latched error, and err_n_o stays low through the following wake-up.
- R10: Wake-up does not complete while any fault flag is high, even with bs_ready_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable line, high to operate |
| uvlo_i | input | 1 | Filtered supply undervoltage lockout |
| scd_i | input | 1 | Filtered short circuit detection |
| lvl_open_i | input | 1 | Short-circuit-level pin found open |
| vreg_uv_i | input | 1 | Regulator undervoltage |
| ov_i | input | 1 | Supply overvoltage warning |
| ot_i | input | 1 | Overtemperature warning |
| oc_i | input | 1 | Overcurrent warning |
| bs_ready_i | input | 1 | Bootstrap capacitors charged |
| err_n_o | output | 1 | Error flag, low on any reported condition |
| gates_off_o | output | 1 | Force all gates off |
| bs_charge_o | output | 1 | Turn on both low sides to charge bootstraps |
| sleep_o | output | 1 | Supplies off, sleep |

## Verification
The main stimulus is the enable line, exercised with three kinds of low period. A glitch just under the reset threshold must leave the outputs alone. A pulse just over the threshold must clear latched faults. A long hold must reach sleep, and comparing it with a hold broken partway through tells the timed window apart from an immediate sleep. Faults are applied singly to sort them by class: warnings leave the gates on, forcing errors switch them off, and the latched error survives removal of its flag. Simultaneous fault pairs (short circuit with open pin, regulator undervoltage with overvoltage, supply undervoltage with short circuit) are chosen so that a wrong priority gives different output bits.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;

   typedef enum logic [2:0] {
      MD_SLEEP     = 3'd0,
      MD_WAKE      = 3'd1,
      MD_RUN       = 3'd2,
      MD_WARN      = 3'd3,
      MD_SOFTERR   = 3'd4,
      MD_LATCHERR  = 3'd5,
      MD_GOSLEEP   = 3'd6,
      MD_SUPPLYERR = 3'd7
   } bdrv_mode_e;

   typedef enum logic [2:0] {
      FC_NONE   = 3'd0,
      FC_WARN   = 3'd1,
      FC_FORCE  = 3'd2,
      FC_LATCH  = 3'd3,
      FC_SUPPLY = 3'd4
   } bdrv_fclass_e;

endpackage

// File: rtl/bdrv_en_qual.sv
module bdrv_en_qual #(
   parameter int CLK_PER_US = 100,
   parameter int RST_US     = 2,
   parameter int SLEEP_US   = 415
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic lo_qual_o,
   output logic sleep_due_o
);
   localparam int CW = $clog2(SLEEP_US + 1);
   localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
      if (RST_US < 1 || RST_US >= SLEEP_US) begin : g_bad_win
         $error("RST_US must be at least 1 and below SLEEP_US");
      end
   endgenerate

   logic          us_tick;
   logic [CW-1:0] lo_q;

   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign us_tick = ~en_i;
      end else begin : g_presc
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pre_q <= '0;
            else if (en_i)                          pre_q <= '0;
            else if (pre_q == PW'(CLK_PER_US - 1))  pre_q <= '0;
            else                                    pre_q <= pre_q + 1'b1;
         end
         assign us_tick = ~en_i & (pre_q == PW'(CLK_PER_US - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lo_q <= '0;
      else if (en_i)                              lo_q <= '0;
      else if (us_tick && lo_q != CW'(SLEEP_US))  lo_q <= lo_q + 1'b1;
   end

   assign lo_qual_o   = ~en_i & (lo_q >= CW'(RST_US));
   assign sleep_due_o = ~en_i & (lo_q == CW'(SLEEP_US));

endmodule

// File: rtl/bdrv_fault_rank.sv
module bdrv_fault_rank #(
   parameter int NUM_WARN = 3
) (
   input  logic                  uvlo_i,
   input  logic                  scd_i,
   input  logic                  lvl_open_i,
   input  logic                  vreg_uv_i,
   input  logic [NUM_WARN-1:0]   warn_i,
   output bdrv_pkg::bdrv_fclass_e fclass_o
);
   import bdrv_pkg::*;

   generate
      if (NUM_WARN < 1) begin : g_bad_warn
         $error("NUM_WARN must be at least 1");
      end
   endgenerate

   logic any_warn;
   assign any_warn = |warn_i;

   always_comb begin
      if (uvlo_i)                       fclass_o = FC_SUPPLY;
      else if (scd_i)                   fclass_o = FC_LATCH;
      else if (lvl_open_i || vreg_uv_i) fclass_o = FC_FORCE;
      else if (any_warn)                fclass_o = FC_WARN;
      else                              fclass_o = FC_NONE;
   end

endmodule

// File: rtl/bdrv_mode_fsm.sv
module bdrv_mode_fsm (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_i,
   input  logic                   lo_qual_i,
   input  logic                   sleep_due_i,
   input  logic                   bs_ready_i,
   input  bdrv_pkg::bdrv_fclass_e fclass_i,
   output bdrv_pkg::bdrv_mode_e   mode_o
);
   import bdrv_pkg::*;

   bdrv_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (fclass_i == FC_SUPPLY && mode_q != MD_SLEEP && mode_q != MD_SUPPLYERR) begin
         mode_d = MD_SUPPLYERR;
      end else if (lo_qual_i && mode_q != MD_SLEEP && mode_q != MD_SUPPLYERR
                   && mode_q != MD_GOSLEEP) begin
         mode_d = MD_GOSLEEP;
      end else begin
         unique case (mode_q)
            MD_SLEEP:     if (en_i && fclass_i != FC_SUPPLY) mode_d = MD_WAKE;
            MD_SUPPLYERR: if (lo_qual_i) mode_d = MD_SLEEP;
            MD_GOSLEEP: begin
               if (en_i)             mode_d = MD_WAKE;
               else if (sleep_due_i) mode_d = MD_SLEEP;
            end
            MD_WAKE: begin
               if (fclass_i == FC_LATCH)                     mode_d = MD_LATCHERR;
               else if (bs_ready_i && fclass_i == FC_NONE)   mode_d = MD_RUN;
            end
            MD_LATCHERR: mode_d = MD_LATCHERR;
            MD_RUN, MD_WARN, MD_SOFTERR: begin
               unique case (fclass_i)
                  FC_LATCH: mode_d = MD_LATCHERR;
                  FC_FORCE: mode_d = MD_SOFTERR;
                  FC_WARN:  mode_d = MD_WARN;
                  default:  mode_d = MD_RUN;
               endcase
            end
            default: mode_d = MD_SLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_SLEEP;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/bdrv_mode_ctrl.sv
module bdrv_mode_ctrl #(
   parameter int CLK_PER_US = 100,
   parameter int RST_US     = 2,
   parameter int SLEEP_US   = 415
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic uvlo_i,
   input  logic scd_i,
   input  logic lvl_open_i,
   input  logic vreg_uv_i,
   input  logic ov_i,
   input  logic ot_i,
   input  logic oc_i,
   input  logic bs_ready_i,
   output logic err_n_o,
   output logic gates_off_o,
   output logic bs_charge_o,
   output logic sleep_o
);
   import bdrv_pkg::*;

   localparam int NUM_WARN = 3;

   logic         lo_qual, sleep_due;
   bdrv_fclass_e fclass;
   bdrv_mode_e   mode;

   bdrv_en_qual #(
      .CLK_PER_US(CLK_PER_US),
      .RST_US    (RST_US),
      .SLEEP_US  (SLEEP_US)
   ) u_en_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .lo_qual_o  (lo_qual),
      .sleep_due_o(sleep_due)
   );

   bdrv_fault_rank #(.NUM_WARN(NUM_WARN)) u_rank (
      .uvlo_i    (uvlo_i),
      .scd_i     (scd_i),
      .lvl_open_i(lvl_open_i),
      .vreg_uv_i (vreg_uv_i),
      .warn_i    ({ov_i, ot_i, oc_i}),
      .fclass_o  (fclass)
   );

   bdrv_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .lo_qual_i  (lo_qual),
      .sleep_due_i(sleep_due),
      .bs_ready_i (bs_ready_i),
      .fclass_i   (fclass),
      .mode_o     (mode)
   );

   always_comb begin
      err_n_o     = (mode == MD_RUN);
      gates_off_o = (mode != MD_RUN) && (mode != MD_WARN);
      bs_charge_o = (mode == MD_WAKE);
      sleep_o     = (mode == MD_SLEEP) || (mode == MD_SUPPLYERR);
   end

   // R4: supply lockout silences the bridge on the next cycle
   p_uvlo_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> (gates_off_o && !err_n_o && !bs_charge_o));

   // R7: latched short circuit error holds until an enable reset
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_LATCHERR && !lo_qual && !uvlo_i) |=> (mode == MD_LATCHERR));

   // R5: a warning in run keeps gates enabled while flagging
   p_warn_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_RUN && fclass == FC_WARN && !lo_qual) |=> (!err_n_o && !gates_off_o));

   // R9: a qualified enable reset keeps the flag low
   p_reset_err_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lo_qual |=> !err_n_o);

   // R2: leaving wake-up for run needs charged bootstraps
   p_wake_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == MD_WAKE && mode == MD_RUN) |-> $past(bs_ready_i));

   // R3: sleep never charges bootstraps nor releases gates
   p_sleep_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (!bs_charge_o && gates_off_o));

endmodule

// File: tb/bdrv_mode_ctrl_bench.sv
module bdrv_mode_ctrl_bench;
   localparam int P = 4;
   localparam int R = 3;
   localparam int S = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, uvlo = 1'b0, scd = 1'b0, lvl_open = 1'b0, vreg_uv = 1'b0;
   logic ov = 1'b0, ot = 1'b0, oc = 1'b0, bs_ready = 1'b0;
   logic err_n, gates_off, bs_charge, sleep_s;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   string       rq[$];
   logic [3:0]  eq[$];

   // output code {err_n, gates_off, bs_charge, sleep}
   localparam logic [3:0] O_SLEEP = 4'b0101;
   localparam logic [3:0] O_WAKE  = 4'b0110;
   localparam logic [3:0] O_RUN   = 4'b1000;
   localparam logic [3:0] O_WARN  = 4'b0000;
   localparam logic [3:0] O_OFF   = 4'b0100;

   always #5 clk = ~clk;

   bdrv_mode_ctrl #(.CLK_PER_US(P), .RST_US(R), .SLEEP_US(S)) u_bdrv_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .scd_i(scd),
      .lvl_open_i(lvl_open), .vreg_uv_i(vreg_uv), .ov_i(ov), .ot_i(ot),
      .oc_i(oc), .bs_ready_i(bs_ready), .err_n_o(err_n),
      .gates_off_o(gates_off), .bs_charge_o(bs_charge), .sleep_o(sleep_s)
   );

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(string req, logic [3:0] exp);
      rq.push_back(req);
      eq.push_back(exp);
   endtask

   task automatic en_low(int n);
      en = 1'b0;
      step(n);
      en = 1'b1;
   endtask

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(negedge clk);
         while (eq.size() > 0) begin
            string      r;
            logic [3:0] e;
            logic [3:0] a;
            r = rq.pop_front();
            e = eq.pop_front();
            a = {err_n, gates_off, bs_charge, sleep_s};
            checks++;
            if (a !== e) begin
               failures++;
               $display("FAIL %s actual=%b expected=%b at %0t", r, a, e, $time);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(3);
      expect_out("R1", O_SLEEP);

      en = 1'b1; step(3);
      expect_out("R2", O_WAKE);
      bs_ready = 1'b1; ov = 1'b1; step(3);
      expect_out("R10", O_WAKE);
      ov = 1'b0; step(3);
      expect_out("R2", O_RUN);

      ov = 1'b1; step(3); expect_out("R5", O_WARN);
      ov = 1'b0; step(3); expect_out("R5", O_RUN);
      oc = 1'b1; step(3); expect_out("R5", O_WARN);
      oc = 1'b0; ot = 1'b1; step(3); expect_out("R5", O_WARN);
      ot = 1'b0; step(3); expect_out("R5", O_RUN);

      vreg_uv = 1'b1; step(3); expect_out("R6", O_OFF);
      vreg_uv = 1'b0; step(3); expect_out("R6", O_RUN);
      lvl_open = 1'b1; step(3); expect_out("R6", O_OFF);
      lvl_open = 1'b0; step(3); expect_out("R6", O_RUN);

      en_low(P*R - 2); step(3); expect_out("R9", O_RUN);

      scd = 1'b1; step(2); scd = 1'b0; step(3);
      expect_out("R7", O_OFF);
      en_low(P*R - 2); step(3); expect_out("R9", O_OFF);
      bs_ready = 1'b0;
      en = 1'b0; step(P*R + 4); expect_out("R9", O_OFF);
      en = 1'b1; step(3); expect_out("R9", O_WAKE);
      bs_ready = 1'b1; step(3); expect_out("R9", O_RUN);

      scd = 1'b1; lvl_open = 1'b1; step(2);
      scd = 1'b0; lvl_open = 1'b0; step(3);
      expect_out("R8", O_OFF);
      en_low(P*R + 4); step(4); expect_out("R8", O_RUN);
      vreg_uv = 1'b1; ov = 1'b1; step(3); expect_out("R8", O_OFF);
      vreg_uv = 1'b0; ov = 1'b0; step(3); expect_out("R8", O_RUN);

      en = 1'b0; step(P*S - 10); expect_out("R3", O_OFF);
      step(15); expect_out("R3", O_SLEEP);
      bs_ready = 1'b0; en = 1'b1; step(3); expect_out("R3", O_WAKE);
      en = 1'b0; step(P*R + 8); expect_out("R3", O_OFF);
      en = 1'b1; step(3); expect_out("R3", O_WAKE);
      bs_ready = 1'b1; step(3); expect_out("R3", O_RUN);

      uvlo = 1'b1; scd = 1'b1; step(3); expect_out("R8", O_SLEEP);
      uvlo = 1'b0; scd = 1'b0; step(3); expect_out("R4", O_SLEEP);
      en = 1'b0; step(P*R + 4); expect_out("R4", O_SLEEP);
      en = 1'b1; step(4); expect_out("R4", O_RUN);
      uvlo = 1'b1; step(2); uvlo = 1'b0; step(3); expect_out("R4", O_SLEEP);

      step(3);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule